// File: doc/BRIEF.md
# Chip-Select Bank Address Matcher

This block decides which of a small set of programmable memory banks an internal bus access is aimed at, and whether that bank should answer. Each bank owns two configuration words. A base word holds the base address, an address-space type, a port size, a write-protect bit, an external-acknowledge bit and an enable bit. A mask word holds the address mask and the type mask. An access offers the upper address bits, a 3-bit address-space type and a read/write flag, and it is announced by a one-cycle start strobe.

On the clock edge that samples the start strobe, the block registers the bank decision. The decision is a one-hot bank hit, the chip-select enables, a request for an internally generated transfer acknowledge and the port size of the selected bank. It holds that decision until an end strobe closes the access. A write that lands on a write-protected bank is refused without a chip select or an acknowledge. Such a write also sets a sticky error flag, which software clears by writing 1 to the status word.

Configuration words are written through a simple write port. With default parameters, word address 2*b is the base word of bank b, 2*b+1 is its mask word, and address 8 is the status word. Writes to any other word address have no effect.

Top module: `csbank_match`

## Requirements
- R1: After reset every bank is disabled, and bank_hit, cs_en, int_ack_req, port_size and wp_err are all 0.
- R2: A bank's address compare succeeds when acc_addr equals the base address in every bit position whose address-mask bit is 1. Positions whose mask bit is 0 are ignored. The base word holds the base address in bits [16:0] and the mask word holds the address mask in bits [16:0].
- R3: A bank hits only when both the address compare and the type compare succeed. The type compare checks acc_type against the type field (base word bits [19:17]) in the positions where the type mask (mask word bits [19:17]) is 1.
- R4: A bank takes part in matching only while its enable bit (base word bit 24) is 1.
- R5: When several banks hit, only the lowest-numbered one is reported, so bank_hit is one-hot or zero.
- R6: port_size reports the selected bank's size field (base word bits [21:20]: 00 = 32-bit, 01 = 8-bit, 10 = 16-bit). The reserved code 11 is reported as 00, and a miss reports 00.
- R7: A write that selects a bank whose write-protect bit (base word bit 22) is 1 still shows that bank on bank_hit, but it asserts neither cs_en nor int_ack_req. A read of such a bank behaves like a read of an unprotected bank.
- R8: wp_err becomes 1 after a write that selects a write-protected bank, and it stays 1 until a status write (word address 8) with data bit 0 equal to 1. A status write with bit 0 equal to 0 leaves it set. When a new error and a clear fall in the same cycle, the flag stays set.
- R9: When the selected bank's external-acknowledge bit (base word bit 23) is 1, cs_en is asserted but int_ack_req stays 0.
- R10: Outputs update on the edge that samples acc_start and then hold, even if the access inputs or the configuration change, until the edge that samples acc_end clears them to 0. If acc_start and acc_end are both high in the same cycle, the start wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration word address |
| cfg_wdata | input | 25 | Configuration write data |
| acc_addr | input | 17 | Compared upper address bits of the access |
| acc_type | input | 3 | Address-space type of the access |
| acc_wr | input | 1 | 1 for a write, 0 for a read |
| acc_start | input | 1 | Transfer-start strobe |
| acc_end | input | 1 | Access-end strobe |
| bank_hit | output | 4 | One-hot selected bank |
| cs_en | output | 4 | Chip-select enables |
| int_ack_req | output | 1 | Request for an internally generated transfer acknowledge |
| port_size | output | 2 | Port size of the selected bank |
| wp_err | output | 1 | Sticky write-protect error flag |

## Verification
Every result of this block is due exactly one clock edge after the strobe that causes it. The bank outputs and the error flag follow the edge that samples acc_start, the cleared outputs follow the edge that samples acc_end, and a status clear takes effect on the edge of its write. The bench changes inputs on falling edges and reads outputs on the next falling edge, so exactly one rising edge separates a stimulus from its check. The hold test leaves several edges between changing the inputs and the configuration and checking that the held values are still unchanged.

// File: rtl/csbank_match.sv
module csbank_match #(
  parameter int NBANK = 4,
  parameter int AW    = 17,
  parameter int TW    = 3,
  parameter int CAW   = $clog2(2*NBANK+1),
  parameter int DW    = AW+TW+5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CAW-1:0]   cfg_addr,
  input  logic [DW-1:0]    cfg_wdata,
  input  logic [AW-1:0]    acc_addr,
  input  logic [TW-1:0]    acc_type,
  input  logic             acc_wr,
  input  logic             acc_start,
  input  logic             acc_end,
  output logic [NBANK-1:0] bank_hit,
  output logic [NBANK-1:0] cs_en,
  output logic             int_ack_req,
  output logic [1:0]       port_size,
  output logic             wp_err
);
  localparam int PT  = AW;
  localparam int PPS = AW+TW;
  localparam int PWP = PPS+2;
  localparam int PXA = PWP+1;
  localparam int PEN = PXA+1;
  localparam logic [CAW-1:0] STAT_ADDR = CAW'(2*NBANK);

  logic [AW-1:0]    base_q  [NBANK];
  logic [AW-1:0]    amask_q [NBANK];
  logic [TW-1:0]    type_q  [NBANK];
  logic [TW-1:0]    tmask_q [NBANK];
  logic [1:0]       size_q  [NBANK];
  logic [NBANK-1:0] wp_q, xa_q, en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NBANK; b++) begin
        base_q[b]  <= '0;
        amask_q[b] <= '0;
        type_q[b]  <= '0;
        tmask_q[b] <= '0;
        size_q[b]  <= '0;
      end
      wp_q <= '0;
      xa_q <= '0;
      en_q <= '0;
    end else if (cfg_we) begin
      for (int b = 0; b < NBANK; b++) begin
        if (cfg_addr == CAW'(2*b)) begin
          base_q[b] <= cfg_wdata[AW-1:0];
          type_q[b] <= cfg_wdata[PT +: TW];
          size_q[b] <= cfg_wdata[PPS +: 2];
          wp_q[b]   <= cfg_wdata[PWP];
          xa_q[b]   <= cfg_wdata[PXA];
          en_q[b]   <= cfg_wdata[PEN];
        end
        if (cfg_addr == CAW'(2*b+1)) begin
          amask_q[b] <= cfg_wdata[AW-1:0];
          tmask_q[b] <= cfg_wdata[PT +: TW];
        end
      end
    end
  end

  logic [NBANK-1:0] match, win;
  logic [1:0]       size_sel;

  always_comb begin
    for (int b = 0; b < NBANK; b++)
      match[b] = en_q[b]
              && (((acc_addr ^ base_q[b]) & amask_q[b]) == '0)
              && (((acc_type ^ type_q[b]) & tmask_q[b]) == '0);
  end

  always_comb begin
    win      = '0;
    size_sel = 2'b00;
    for (int b = NBANK-1; b >= 0; b--) begin
      if (match[b]) begin
        win      = '0;
        win[b]   = 1'b1;
        size_sel = size_q[b];
      end
    end
  end

  wire any_hit  = |win;
  wire blocked  = acc_wr & |(win & wp_q);
  wire ext_ack  = |(win & xa_q);
  wire err_clr  = cfg_we && cfg_addr == STAT_ADDR && cfg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_hit    <= '0;
      cs_en       <= '0;
      int_ack_req <= 1'b0;
      port_size   <= 2'b00;
    end else if (acc_start) begin
      bank_hit    <= win;
      cs_en       <= blocked ? '0 : win;
      int_ack_req <= any_hit & ~blocked & ~ext_ack;
      port_size   <= (size_sel == 2'b11) ? 2'b00 : size_sel;
    end else if (acc_end) begin
      bank_hit    <= '0;
      cs_en       <= '0;
      int_ack_req <= 1'b0;
      port_size   <= 2'b00;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          wp_err <= 1'b0;
    else if (acc_start && any_hit && blocked) wp_err <= 1'b1;
    else if (err_clr)                    wp_err <= 1'b0;
  end

  AST_HIT_ONEHOT:   assert property (@(posedge clk) disable iff (!rst_n) $onehot0(bank_hit)); // R5
  AST_CS_IN_HIT:    assert property (@(posedge clk) disable iff (!rst_n) (cs_en & ~bank_hit) == '0); // R7
  AST_ACK_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n) int_ack_req |-> (cs_en != '0)); // R9
  AST_WP_BLOCK:     assert property (@(posedge clk) disable iff (!rst_n)
                      (acc_start && acc_wr && (win & wp_q) != '0) |=> (cs_en == '0 && !int_ack_req && wp_err)); // R7
  AST_ERR_STICKY:   assert property (@(posedge clk) disable iff (!rst_n)
                      (wp_err && !(cfg_we && cfg_addr == STAT_ADDR)) |=> wp_err); // R8
  AST_HOLD:         assert property (@(posedge clk) disable iff (!rst_n)
                      (!acc_start && !acc_end) |=> ($stable(bank_hit) && $stable(cs_en) && $stable(port_size))); // R10
  AST_END_CLEARS:   assert property (@(posedge clk) disable iff (!rst_n)
                      (acc_end && !acc_start) |=> (bank_hit == '0 && cs_en == '0 && !int_ack_req)); // R10
endmodule

// File: tb/csbank_match_tb.sv
module csbank_match_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [24:0] cfg_wdata = '0;
  logic [16:0] acc_addr = '0;
  logic [2:0]  acc_type = '0;
  logic        acc_wr = 1'b0, acc_start = 1'b0, acc_end = 1'b0;
  logic [3:0]  bank_hit, cs_en;
  logic        int_ack_req, wp_err;
  logic [1:0]  port_size;

  csbank_match dut_i (.*);

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  logic [31:0] seed = 32'h1234_5678;

  logic [16:0] m_base [4], m_am [4];
  logic [2:0]  m_ty [4], m_tm [4];
  logic [1:0]  m_ps [4];
  logic [3:0]  m_wp, m_xa, m_en;
  logic [3:0]  e_hit, e_cs;
  logic        e_ack, e_err;
  logic [1:0]  e_ps;

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  task automatic check(input string lbl, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", lbl, act, exp);
    end
  endtask

  task automatic wr_cfg(input logic [3:0] a, input logic [24:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_bank(input int b, input logic [16:0] base, input logic [16:0] am,
                          input logic [2:0] ty, input logic [2:0] tm, input logic [1:0] ps,
                          input logic wp, input logic xa, input logic en);
    m_base[b] = base; m_am[b] = am; m_ty[b] = ty; m_tm[b] = tm; m_ps[b] = ps;
    m_wp[b] = wp; m_xa[b] = xa; m_en[b] = en;
    wr_cfg(4'(2*b), {en, xa, wp, ps, ty, base});
    wr_cfg(4'(2*b+1), {5'b0, tm, am});
  endtask

  task automatic model(input logic [16:0] a, input logic [2:0] t, input logic w);
    int win = -1;
    for (int b = 3; b >= 0; b--)
      if (m_en[b] && ((a ^ m_base[b]) & m_am[b]) == 17'd0 && ((t ^ m_ty[b]) & m_tm[b]) == 3'd0)
        win = b;
    e_hit = '0; e_cs = '0; e_ack = 1'b0; e_ps = 2'b00;
    if (win >= 0) begin
      e_hit = 4'(1 << win);
      e_cs  = (w && m_wp[win]) ? 4'd0 : e_hit;
      e_ack = !(w && m_wp[win]) && !m_xa[win];
      e_ps  = (m_ps[win] == 2'b11) ? 2'b00 : m_ps[win];
      if (w && m_wp[win]) e_err = 1'b1;
    end
  endtask

  task automatic run_acc(input logic [16:0] a, input logic [2:0] t, input logic w, input string lbl);
    model(a, t, w);
    @(negedge clk);
    acc_addr = a; acc_type = t; acc_wr = w; acc_start = 1'b1;
    @(negedge clk);
    acc_start = 1'b0;
    check({lbl, " R5 bank_hit"}, 32'(bank_hit), 32'(e_hit));
    check("R7 cs_en", 32'(cs_en), 32'(e_cs));
    check("R9 int_ack_req", 32'(int_ack_req), 32'(e_ack));
    check("R6 port_size", 32'(port_size), 32'(e_ps));
    check("R8 wp_err", 32'(wp_err), 32'(e_err));
    acc_end = 1'b1;
    @(negedge clk);
    acc_end = 1'b0;
    check("R10 cleared after end", 32'({bank_hit, cs_en, int_ack_req, port_size}), 32'd0);
  endtask

  task automatic clear_err(input logic bit0);
    wr_cfg(4'd8, {24'd0, bit0});
    if (bit0) e_err = 1'b0;
    check("R8 status write", 32'(wp_err), 32'(e_err));
  endtask

  initial begin
    repeat (2000 * 100) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    m_wp = '0; m_xa = '0; m_en = '0; e_err = 1'b0;
    for (int b = 0; b < 4; b++) begin
      m_base[b] = '0; m_am[b] = '0; m_ty[b] = '0; m_tm[b] = '0; m_ps[b] = '0;
    end
    repeat (3) @(negedge clk);
    check("R1 reset outputs", 32'({bank_hit, cs_en, int_ack_req, port_size, wp_err}), 32'd0);
    rst_n = 1'b1;
    run_acc(17'h00000, 3'd0, 1'b0, "R1 R4 all disabled");

    set_bank(0, 17'h00100, 17'h1FF00, 3'd0, 3'd0, 2'b01, 1'b0, 1'b0, 1'b1);
    set_bank(1, 17'h00200, 17'h1FF00, 3'd5, 3'd7, 2'b10, 1'b1, 1'b0, 1'b1);
    set_bank(2, 17'h00000, 17'h1F000, 3'd0, 3'd0, 2'b11, 1'b0, 1'b1, 1'b1);
    set_bank(3, 17'h00300, 17'h1FF00, 3'd0, 3'd0, 2'b10, 1'b0, 1'b0, 1'b0);

    run_acc(17'h001A5, 3'd2, 1'b0, "R2 R5 bank0 over bank2");
    run_acc(17'h002FF, 3'd5, 1'b0, "R3 R7 protected read");
    run_acc(17'h00210, 3'd4, 1'b0, "R3 type mismatch");
    run_acc(17'h00310, 3'd0, 1'b0, "R4 disabled bank3");
    run_acc(17'h00310, 3'd0, 1'b1, "R9 R6 ext ack reserved size");
    run_acc(17'h10100, 3'd0, 1'b0, "R2 miss");
    run_acc(17'h00201, 3'd5, 1'b1, "R7 protected write");
    clear_err(1'b0);
    clear_err(1'b1);

    for (int i = 0; i < 400; i++) begin
      logic [31:0] r = rnd();
      logic [16:0] a = 17'(r[9:0]) | (r[20] ? 17'h10000 : 17'h0);
      run_acc(a, r[13:11], r[14], "R2 R3 sweep A");
      if (i % 37 == 36) clear_err(1'b1);
    end

    for (int s = 0; s < 4; s++) begin
      for (int b = 0; b < 4; b++) begin
        logic [31:0] r1 = rnd();
        logic [31:0] r2 = rnd();
        set_bank(b, 17'(r1), 17'(r2) | 17'h1F000, r1[19:17], r2[22:20], r2[24:23],
                 r1[25], r1[26], r1[28:27] != 2'b00);
      end
      for (int i = 0; i < 250; i++) begin
        logic [31:0] r = rnd();
        logic [31:0] q = rnd();
        int k = int'(r[1:0]);
        logic [16:0] a = m_base[k] ^ (17'(q) & ~m_am[k]);
        logic [2:0]  t = r[4] ? (m_ty[k] ^ (q[19:17] & ~m_tm[k])) : q[22:20];
        if (r[5]) a = a ^ (17'd1 << (int'(r[12:8]) % 17));
        run_acc(a, t, r[6], "R2 R3 R4 sweep B");
        if (i % 41 == 40) clear_err(r[7]);
      end
    end

    set_bank(0, 17'h00100, 17'h1FF00, 3'd0, 3'd0, 2'b01, 1'b0, 1'b0, 1'b1);
    set_bank(1, 17'h00200, 17'h1FF00, 3'd5, 3'd7, 2'b10, 1'b1, 1'b0, 1'b1);
    clear_err(1'b1);

    // R10: held through input and configuration changes
    @(negedge clk);
    acc_addr = 17'h00123; acc_type = 3'd1; acc_wr = 1'b0; acc_start = 1'b1;
    @(negedge clk);
    acc_start = 1'b0; acc_addr = 17'h10000;
    cfg_we = 1'b1; cfg_addr = 4'd0; cfg_wdata = '0;
    @(negedge clk);
    cfg_we = 1'b0;
    repeat (2) @(negedge clk);
    check("R10 hold bank_hit", 32'(bank_hit), 32'h1);
    check("R10 hold cs_en/ack/size", 32'({cs_en, int_ack_req, port_size}), 32'({4'h1, 1'b1, 2'b01}));
    acc_end = 1'b1;
    @(negedge clk);
    acc_end = 1'b0;
    check("R10 end clears", 32'({bank_hit, cs_en}), 32'd0);
    set_bank(0, 17'h00100, 17'h1FF00, 3'd0, 3'd0, 2'b01, 1'b0, 1'b0, 1'b1);

    // R10: start beats end in the same cycle
    @(negedge clk);
    acc_addr = 17'h00200; acc_type = 3'd5; acc_wr = 1'b0; acc_start = 1'b1; acc_end = 1'b1;
    @(negedge clk);
    acc_start = 1'b0; acc_end = 1'b0;
    check("R10 start wins over end", 32'({bank_hit, port_size}), 32'({4'h2, 2'b10}));

    // R8: new error beats a clear in the same cycle
    @(negedge clk);
    acc_wr = 1'b1; acc_start = 1'b1;
    cfg_we = 1'b1; cfg_addr = 4'd8; cfg_wdata = 25'd1;
    @(negedge clk);
    acc_start = 1'b0; cfg_we = 1'b0;
    check("R8 set beats clear", 32'(wp_err), 32'd1);
    check("R7 write blocked", 32'({bank_hit, cs_en, int_ack_req}), 32'({4'h2, 4'h0, 1'b0}));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule